// File: doc/BRIEF.md
# Reset Source Arbiter and Exception-Start Sequencer

This block decides what kind of reset the chip is in and when reset exception processing may begin. It watches an active-low external reset pin, a one-cycle watchdog overflow strobe and a watchdog configuration bit that picks the flavour of reset the watchdog produces. From these it drives two separate reset outputs: one for the processor-side logic (integer core, multiplier, floating-point unit, interrupt controller) and one for the on-chip peripherals together with the pin-function and IO-port registers.

Two reset flavours exist. The power-on flavour asserts both outputs; the manual flavour asserts only the processor-side output and leaves peripheral state alone. The block also drives a reset-kind flag and a one-cycle pulse that tells the processor to begin fetching its start vectors. The external pin passes through a synchronizer and must stay low long enough to be trusted; short glitches are discarded. A watchdog reset holds the processor for a fixed number of cycles; a qualified pin assertion arriving during it turns it into a power-on reset.

Top module: `reset_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cpu_rst`, `periph_rst`, `vec_start` and `rst_kind` are all 0.
- R2: `ext_rst_n` passes through a two-stage synchronizer; once it has been sampled low on 10 consecutive rising edges, both `cpu_rst` and `periph_rst` go high after the 12th of those edges, counting the first edge that samples the pin low, and `rst_kind` reads 0 (power-on).
- R3: A low pulse on `ext_rst_n` sampled on fewer than 10 consecutive edges has no effect on any output.
- R4: A pin-initiated reset stays asserted while the synchronized pin is low; when the synchronized pin reads high, both resets drop and `vec_start` is 1 for that same cycle.
- R5: With `wdog_manual` = 1, a `wdog_ovf` strobe in normal operation holds `cpu_rst` high for exactly 16 cycles with `periph_rst` low and `rst_kind` = 1 (manual), then gives the `vec_start` cycle.
- R6: With `wdog_manual` = 0, a `wdog_ovf` strobe holds both resets high for exactly 16 cycles with `rst_kind` = 0, then gives the `vec_start` cycle.
- R7: `rst_kind` keeps its value from the cycle a reset asserts through the `vec_start` cycle, changing only to 0 on an upgrade, and holds afterwards until the next reset.
- R8: `vec_start` is never high on two consecutive cycles, and `periph_rst` is never high without `cpu_rst`.
- R9: A pin qualification during a watchdog hold turns it into a pin-held power-on reset: `periph_rst` rises, `rst_kind` becomes 0, and release follows R4.
- R10: A `wdog_ovf` strobe during an ongoing reset is ignored, and a pin qualification in the same cycle as a strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller itself |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_ovf | input | 1 | Watchdog overflow strobe, one cycle |
| wdog_manual | input | 1 | 1: watchdog gives the manual flavour, 0: power-on flavour |
| cpu_rst | output | 1 | Reset for core, multiplier, FPU and interrupt controller |
| periph_rst | output | 1 | Reset for peripherals and pin-function/IO-port registers |
| rst_kind | output | 1 | Reset flavour: 0 power-on, 1 manual |
| vec_start | output | 1 | One-cycle pulse that starts the vector fetch |

## Verification
The bench pushes the pin exactly at the qualification boundary, 9 and 10 low cycles: a design with an off-by-one counter would either reset on a glitch or miss a legal assertion. It runs both watchdog flavours and measures the hold length, catching a timer that stops one cycle early or late, or that leaks the peripheral reset into a manual reset. It raises the pin during a manual watchdog hold and fires the watchdog in the very cycle the pin qualifies, so a design that failed to upgrade would leave peripheral state intact and report the manual kind. A second strobe during a hold and during a pin reset exposes a design that restarts the timer or emits a second start pulse.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_PIN = 2'd1,
        ST_WDT = 2'd2,
        ST_GO  = 2'd3
    } rc_state_e;

    typedef enum logic {
        KIND_POWERON = 1'b0,
        KIND_MANUAL  = 1'b1
    } rc_kind_e;

    typedef struct packed {
        logic     cpu;
        logic     periph;
        logic     go;
        rc_kind_e kind;
    } rc_out_t;

    function automatic rc_out_t rc_decode(rc_state_e st, rc_kind_e k);
        rc_out_t o;
        o.cpu    = (st == ST_PIN) || (st == ST_WDT);
        o.periph = o.cpu && (k == KIND_POWERON);
        o.go     = (st == ST_GO);
        o.kind   = k;
        return o;
    endfunction

endpackage

// File: rtl/rc_pin_qual.sv
module rc_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_low_o,
    output logic pin_hit_o
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b1;
                else     sync_q[0] <= pin_n;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign pin_low_o = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !pin_low_o)
            low_cnt <= '0;
        else if (low_cnt != CW'(MIN_LOW))
            low_cnt <= low_cnt + 1'b1;
    end

    assign pin_hit_o = pin_low_o && (low_cnt == CW'(MIN_LOW - 1));

    p_hit_once_r2: assert property (@(posedge clk) disable iff (rst)
        pin_hit_o |=> !pin_hit_o);

    p_hit_after_low_r3: assert property (@(posedge clk) disable iff (rst)
        pin_hit_o |-> $past(pin_low_o));

endmodule

// File: rtl/rc_hold_timer.sv
module rc_hold_timer #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int TW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || load_i)
            cnt <= '0;
        else if (run_i && !done_o)
            cnt <= cnt + 1'b1;
    end

    assign done_o = run_i && (cnt == TW'(HOLD - 1));

    p_load_clears_r5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !done_o);

endmodule

// File: rtl/rc_seq.sv
module rc_seq
    import rc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pin_low_i,
    input  logic    pin_hit_i,
    input  logic    wdog_ovf_i,
    input  logic    wdog_manual_i,
    input  logic    hold_done_i,
    output logic    hold_load_o,
    output logic    hold_run_o,
    output rc_out_t out_o
);
    rc_state_e state, state_nxt;
    rc_kind_e  kind,  kind_nxt;

    always_comb begin
        state_nxt   = state;
        kind_nxt    = kind;
        hold_load_o = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (pin_hit_i) begin
                    state_nxt = ST_PIN;
                    kind_nxt  = KIND_POWERON;
                end else if (wdog_ovf_i) begin
                    state_nxt   = ST_WDT;
                    kind_nxt    = wdog_manual_i ? KIND_MANUAL : KIND_POWERON;
                    hold_load_o = 1'b1;
                end
            end
            ST_PIN: begin
                if (!pin_low_i) state_nxt = ST_GO;
            end
            ST_WDT: begin
                if (pin_hit_i) begin
                    state_nxt = ST_PIN;
                    kind_nxt  = KIND_POWERON;
                end else if (hold_done_i) begin
                    state_nxt = ST_GO;
                end
            end
            ST_GO: begin
                if (pin_hit_i) begin
                    state_nxt = ST_PIN;
                    kind_nxt  = KIND_POWERON;
                end else begin
                    state_nxt = ST_RUN;
                end
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            kind  <= KIND_POWERON;
        end else begin
            state <= state_nxt;
            kind  <= kind_nxt;
        end
    end

    assign hold_run_o = (state == ST_WDT);
    assign out_o      = rc_decode(state, kind);

    p_go_single_r8: assert property (@(posedge clk) disable iff (rst)
        out_o.go |=> !out_o.go);

    p_go_after_reset_r4: assert property (@(posedge clk) disable iff (rst)
        out_o.go |-> $past(out_o.cpu));

    p_pin_release_r4: assert property (@(posedge clk) disable iff (rst)
        (out_o.cpu && out_o.periph && !hold_run_o && !pin_low_i) |=> out_o.go);

    p_kind_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_o.cpu && $past(out_o.cpu)) |-> ($stable(out_o.kind) || out_o.kind == KIND_POWERON));

    p_kind_at_go_r7: assert property (@(posedge clk) disable iff (rst)
        out_o.go |-> $stable(out_o.kind));

    p_upgrade_r9: assert property (@(posedge clk) disable iff (rst)
        (hold_run_o && pin_hit_i) |=> (out_o.periph && out_o.kind == KIND_POWERON));

endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl
    import rc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 10,
    parameter int WDT_HOLD    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n,
    input  logic wdog_ovf,
    input  logic wdog_manual,
    output logic cpu_rst,
    output logic periph_rst,
    output logic rst_kind,
    output logic vec_start
);
    logic    pin_low, pin_hit;
    logic    hold_load, hold_run, hold_done;
    rc_out_t outs;

    rc_pin_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW     (MIN_LOW)
    ) u_pin (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ext_rst_n),
        .pin_low_o (pin_low),
        .pin_hit_o (pin_hit)
    );

    rc_hold_timer #(
        .HOLD (WDT_HOLD)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (hold_load),
        .run_i  (hold_run),
        .done_o (hold_done)
    );

    rc_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .pin_low_i     (pin_low),
        .pin_hit_i     (pin_hit),
        .wdog_ovf_i    (wdog_ovf),
        .wdog_manual_i (wdog_manual),
        .hold_done_i   (hold_done),
        .hold_load_o   (hold_load),
        .hold_run_o    (hold_run),
        .out_o         (outs)
    );

    assign cpu_rst    = outs.cpu;
    assign periph_rst = outs.periph;
    assign vec_start  = outs.go;
    assign rst_kind   = outs.kind;

    p_periph_needs_cpu_r8: assert property (@(posedge clk) disable iff (rst)
        periph_rst |-> cpu_rst);

    p_ovf_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst && $past(cpu_rst) && wdog_ovf) |=> (cpu_rst || vec_start));

endmodule

// File: tb/tb_reset_ctrl.sv
module tb_reset_ctrl;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, ext_rst_n, wdog_ovf, wdog_manual;
    logic cpu_rst, periph_rst, rst_kind, vec_start;

    reset_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .ext_rst_n   (ext_rst_n),
        .wdog_ovf    (wdog_ovf),
        .wdog_manual (wdog_manual),
        .cpu_rst     (cpu_rst),
        .periph_rst  (periph_rst),
        .rst_kind    (rst_kind),
        .vec_start   (vec_start)
    );

    int    checks = 0, errors = 0, cycles = 0;
    string req = "R1";
    bit    armed = 0;

    // behavioural reference
    bit m_s1, m_s2, m_kind;
    int m_run, m_mode, m_wcnt;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_run = 0; m_mode = 0; m_wcnt = 0; m_kind = 0;
        end else begin
            bit low, hit;
            low   = !m_s2;
            m_run = low ? m_run + 1 : 0;
            hit   = (m_run == 10);
            case (m_mode)
                0: if (hit) begin m_mode = 1; m_kind = 0; end
                   else if (wdog_ovf) begin m_mode = 2; m_kind = wdog_manual; m_wcnt = 0; end
                1: if (!low) m_mode = 3;
                2: if (hit) begin m_mode = 1; m_kind = 0; end
                   else if (m_wcnt == 15) m_mode = 3;
                   else m_wcnt++;
                default: if (hit) begin m_mode = 1; m_kind = 0; end
                         else m_mode = 0;
            endcase
            m_s2 = m_s1;
            m_s1 = ext_rst_n;
        end
    end

    int  cpu_hi = 0, per_hi = 0, go_cnt = 0;
    bit  prev_go = 0;

    always @(negedge clk) begin
        if (armed) begin
            bit e_cpu, e_per, e_go;
            e_cpu = (m_mode == 1) || (m_mode == 2);
            e_per = e_cpu && !m_kind;
            e_go  = (m_mode == 3);
            checks++;
            if (cpu_rst !== e_cpu || periph_rst !== e_per || vec_start !== e_go || rst_kind !== m_kind) begin
                errors++;
                $display("FAIL %s cpu/periph/go/kind actual %b%b%b%b expected %b%b%b%b t=%0t",
                         req, cpu_rst, periph_rst, vec_start, rst_kind, e_cpu, e_per, e_go, m_kind, $time);
            end
            checks++;
            if ((prev_go && vec_start) || (periph_rst && !cpu_rst)) begin
                errors++;
                $display("FAIL R8 go_prev=%b go=%b periph=%b cpu=%b expected no double pulse, periph within cpu",
                         prev_go, vec_start, periph_rst, cpu_rst);
            end
            prev_go = vec_start;
            if (cpu_rst) cpu_hi++;
            if (periph_rst) per_hi++;
            if (vec_start) go_cnt++;
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string r, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        cpu_hi = 0; per_hi = 0; go_cnt = 0;
    endtask

    initial begin
        rst = 1; ext_rst_n = 1; wdog_ovf = 0; wdog_manual = 0;
        @(posedge clk);
        armed = 1;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        chk(cpu_rst == 0 && periph_rst == 0, "R1", "resets after init", cpu_rst + periph_rst, 0);
        chk(vec_start == 0 && rst_kind == 0, "R1", "go/kind after init", vec_start + rst_kind, 0);

        // R3 nine-cycle glitch
        req = "R3"; clr();
        ext_rst_n = 0; cyc(9); ext_rst_n = 1; cyc(20);
        chk(cpu_hi == 0, "R3", "cpu_rst cycles after short pulse", cpu_hi, 0);
        chk(go_cnt == 0, "R3", "start pulses after short pulse", go_cnt, 0);

        // R2 exact ten-cycle pulse
        req = "R2"; clr();
        ext_rst_n = 0; cyc(10); ext_rst_n = 1; cyc(20);
        chk(per_hi > 0 && per_hi == cpu_hi, "R2", "periph cycles equal cpu cycles", per_hi, cpu_hi);
        chk(go_cnt == 1, "R4", "start pulses after pin release", go_cnt, 1);

        // R2/R4 long hold: first assertion timing then release
        req = "R4"; clr();
        ext_rst_n = 0; cyc(12);
        chk(cpu_rst == 1 && rst_kind == 0, "R2", "cpu_rst after 12 edges", cpu_rst, 1);
        cyc(30); ext_rst_n = 1; cyc(15);
        chk(go_cnt == 1, "R4", "start pulses after long hold", go_cnt, 1);
        chk(cpu_rst == 0, "R4", "cpu_rst after release", cpu_rst, 0);

        // R5 manual watchdog
        req = "R5"; clr(); wdog_manual = 1;
        wdog_ovf = 1; cyc(1); wdog_ovf = 0; cyc(25);
        chk(cpu_hi == 16, "R5", "manual hold cycles", cpu_hi, 16);
        chk(per_hi == 0, "R5", "periph cycles in manual", per_hi, 0);
        chk(rst_kind == 1, "R7", "kind held after manual start", rst_kind, 1);

        // R6 power-on watchdog
        req = "R6"; clr(); wdog_manual = 0;
        wdog_ovf = 1; cyc(1); wdog_ovf = 0; cyc(25);
        chk(cpu_hi == 16 && per_hi == 16, "R6", "power-on hold cycles", per_hi, 16);
        chk(go_cnt == 1, "R6", "start pulses", go_cnt, 1);

        // R10 second strobe during hold
        req = "R10"; clr(); wdog_manual = 1;
        wdog_ovf = 1; cyc(1); wdog_ovf = 0; cyc(5);
        wdog_manual = 0; wdog_ovf = 1; cyc(1); wdog_ovf = 0; cyc(25);
        chk(cpu_hi == 16, "R10", "hold not restarted", cpu_hi, 16);
        chk(per_hi == 0 && go_cnt == 1, "R10", "kind not changed by strobe", per_hi, 0);

        // R10 strobe in the very cycle the pin qualifies, then during pin reset
        clr(); wdog_manual = 1;
        ext_rst_n = 0; cyc(11); wdog_ovf = 1; cyc(1); wdog_ovf = 0;
        cyc(4); wdog_ovf = 1; cyc(1); wdog_ovf = 0; cyc(4);
        chk(periph_rst == 1 && rst_kind == 0, "R10", "pin wins over strobe", periph_rst, 1);
        ext_rst_n = 1; cyc(15);
        chk(go_cnt == 1, "R10", "single start after mixed sources", go_cnt, 1);

        // R9 upgrade during manual hold
        req = "R9"; clr(); wdog_manual = 1;
        wdog_ovf = 1; cyc(1); wdog_ovf = 0; cyc(2);
        ext_rst_n = 0; cyc(20);
        chk(periph_rst == 1 && rst_kind == 0, "R9", "upgraded to power-on", rst_kind, 0);
        ext_rst_n = 1; cyc(15);
        chk(go_cnt == 1 && per_hi > 0, "R9", "start pulses after upgrade", go_cnt, 1);

        // R7 kind persists into normal operation
        req = "R7";
        cyc(5);
        chk(rst_kind == 0, "R7", "kind after upgraded reset", rst_kind, 0);

        summary();
        $finish;
    end
endmodule